// File: doc/BRIEF.md
# Voice Playback Chip Command Sequencer

This block turns one-cycle commands from a processor register interface into the pin sequences needed by two voice playback chips. One chip holds looping background music. The other holds two short clips, a row-clear jingle and an end-of-game jingle. Each chip is driven through an 8-bit address/mode bus, an active-low chip select, an edge-type start strobe, a level-type stop strobe and a record strobe. The record strobe is parked high because recording is not part of this block.

The 8-bit bus has two roles. With bits 7:6 at `00`, bits 5:0 name a message address. With bits 7:6 at `11`, bits 5:0 are mode flags, and bit 3 selects looping. The sequencer starts background music by selecting looping mode and pulsing the start strobe. It stops the music by pulsing the stop strobe under the same mode word. It plays a clip by placing `00` plus the clip address on the bus and then pulsing the start strobe. In every case chip select and the bus word are applied first and held for a parameterised setup time. The strobe is then held low for a parameterised width, followed by a parameterised hold time, after which everything returns to idle.

While a sequence is running, `busy` is high and any new command is dropped. The block keeps its own record of whether the looping music is running. It reports this on `music_playing` and uses it to drop start and stop commands that would have no effect.

Top module: `voice_cmd_seq`

## Requirements
- R1: After reset, `busy` and `music_playing` are 0, both chip selects and all start, stop and record strobes are 1, and both address buses are 0.
- R2: An accepted music start drives chip 0 (`bg_*`) with address word 8'hC8 (bits 7:6 = 11 for mode, bit 3 = 1 for looping) and pulses `bg_start_n` low, while `bg_stop_n` stays high.
- R3: An accepted music stop drives chip 0 with the same word 8'hC8 and pulses `bg_stop_n` low, while `bg_start_n` stays high.
- R4: An accepted clip command drives chip 1 (`fx_*`) with {2'b00, clip address} and pulses `fx_start_n` low. `clip_sel`=0 selects ROW_CLIP (default 6'h05) and `clip_sel`=1 selects END_CLIP (default 6'h12). `fx_stop_n` never goes low.
- R5: Chip select and the address word of the target chip are stable for exactly SETUP_CYC cycles (default 3) before its strobe falls. A strobe is never low while its chip select is high.
- R6: Every strobe stays low for exactly PULSE_CYC cycles (default 4).
- R7: `busy` rises in the cycle after a command is accepted and stays high for SETUP_CYC+PULSE_CYC+HOLD_CYC cycles (default 9). When `busy` is low, both chip selects are high and all strobes are high.
- R8: A command presented while `busy` is high is ignored: it produces no strobe and does not change `music_playing`.
- R9: `music_playing` goes to 1 in the cycle in which a start sequence ends and to 0 in the cycle in which a stop sequence ends. A start while playing and a stop while not playing are ignored, so `busy` stays low.
- R10: When several eligible commands arrive in the same cycle, stop is taken over start, and start is taken over clip. The commands that are not taken are dropped.
- R11: `bg_rec_n` and `fx_rec_n` are always 1. Only one chip select is low at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_music_start | input | 1 | One-cycle request to start looping music |
| cmd_music_stop | input | 1 | One-cycle request to stop looping music |
| cmd_clip_play | input | 1 | One-cycle request to play a clip |
| clip_sel | input | 1 | Clip choice: 0 row-clear, 1 end-of-game |
| busy | output | 1 | A strobe sequence is in progress |
| music_playing | output | 1 | Looping music is running |
| bg_addr | output | 8 | Music chip address/mode bus |
| bg_cs_n | output | 1 | Music chip select, active low |
| bg_start_n | output | 1 | Music chip edge start strobe, active low |
| bg_stop_n | output | 1 | Music chip level stop strobe, active low |
| bg_rec_n | output | 1 | Music chip record strobe, held high |
| fx_addr | output | 8 | Clip chip address/mode bus |
| fx_cs_n | output | 1 | Clip chip select, active low |
| fx_start_n | output | 1 | Clip chip edge start strobe, active low |
| fx_stop_n | output | 1 | Clip chip level stop strobe, active low |
| fx_rec_n | output | 1 | Clip chip record strobe, held high |

## Verification
A corrupted phase counter would show up at the pins within one sequence. The strobe would fall after the wrong number of setup cycles, stay low for the wrong width, or `busy` would hold for the wrong length, and the bench measures each of these in cycles on every sequence. A wrong job record would make the next strobe appear on the wrong chip, on the wrong line, or under the wrong address word. The scoreboard catches this at the strobe's falling edge. A wrong playing flag would show up only at the next start or stop command, which would then be taken or dropped when it should not be, so the bench issues redundant starts and stops straight after each state change.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

    localparam int BUS_W   = 8;
    localparam int FIELD_W = 6;
    localparam int LOOP_BIT = 3;

    localparam logic CHIP_MUSIC = 1'b0;
    localparam logic CHIP_CLIP  = 1'b1;
    localparam int   NUM_CHIPS  = 2;

    typedef enum logic [1:0] {
        JOB_NONE,
        JOB_LOOP_START,
        JOB_LOOP_STOP,
        JOB_CLIP
    } job_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        job_kind_e          kind;
        logic               chip;
        logic [BUS_W-1:0]   word;
    } job_t;

    typedef struct packed {
        logic [BUS_W-1:0]   addr;
        logic               sel_n;
        logic               start_n;
        logic               stop_n;
        logic               rec_n;
    } pins_t;

    // Upper field 11: lower bits are mode flags.
    function automatic logic [BUS_W-1:0] mode_word(input logic [FIELD_W-1:0] flags);
        return {2'b11, flags};
    endfunction

    // Upper field 00: lower bits are a message address.
    function automatic logic [BUS_W-1:0] clip_word(input logic [FIELD_W-1:0] where);
        return {2'b00, where};
    endfunction

    function automatic logic [FIELD_W-1:0] loop_flags();
        logic [FIELD_W-1:0] f;
        f = '0;
        f[LOOP_BIT] = 1'b1;
        return f;
    endfunction

    localparam job_t IDLE_JOB = '{kind: JOB_NONE, chip: 1'b0, word: '0};

endpackage

// File: rtl/vpc_cmd_arbiter.sv
module vpc_cmd_arbiter
    import vpc_pkg::*;
#(
    parameter logic [FIELD_W-1:0] ROW_CLIP = 6'h05,
    parameter logic [FIELD_W-1:0] END_CLIP = 6'h12
) (
    input  logic  want_start,
    input  logic  want_stop,
    input  logic  want_clip,
    input  logic  clip_choice,
    input  logic  seq_busy,
    input  logic  loop_running,
    output logic  take,
    output job_t  job
);
    logic stop_ok, start_ok;

    assign stop_ok  = want_stop  &&  loop_running;
    assign start_ok = want_start && !loop_running;

    always_comb begin
        take = 1'b0;
        job  = IDLE_JOB;
        if (!seq_busy) begin
            if (stop_ok) begin
                take      = 1'b1;
                job.kind  = JOB_LOOP_STOP;
                job.chip  = CHIP_MUSIC;
                job.word  = mode_word(loop_flags());
            end else if (start_ok) begin
                take      = 1'b1;
                job.kind  = JOB_LOOP_START;
                job.chip  = CHIP_MUSIC;
                job.word  = mode_word(loop_flags());
            end else if (want_clip) begin
                take      = 1'b1;
                job.kind  = JOB_CLIP;
                job.chip  = CHIP_CLIP;
                job.word  = clip_word(clip_choice ? END_CLIP : ROW_CLIP);
            end
        end
    end
endmodule

// File: rtl/vpc_strobe_seq.sv
module vpc_strobe_seq
    import vpc_pkg::*;
#(
    parameter int SETUP_CYC = 3,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   take,
    input  job_t   job_in,
    output phase_e phase,
    output job_t   job_cur,
    output logic   seq_busy,
    output logic   seq_done
);
    localparam int MAX_A  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_C  = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] SETUP_END = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_END  = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             at_end;

    always_comb begin
        unique case (phase)
            PH_SETUP:  at_end = (cnt == SETUP_END);
            PH_STROBE: at_end = (cnt == PULSE_END);
            PH_HOLD:   at_end = (cnt == HOLD_END);
            default:   at_end = 1'b0;
        endcase
    end

    assign seq_busy = (phase != PH_IDLE);
    assign seq_done = (phase == PH_HOLD) && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            job_cur <= IDLE_JOB;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (take) begin
                        job_cur <= job_in;
                        phase   <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    cnt   <= at_end ? '0 : cnt + 1'b1;
                    if (at_end) phase <= PH_STROBE;
                end
                PH_STROBE: begin
                    cnt   <= at_end ? '0 : cnt + 1'b1;
                    if (at_end) phase <= PH_HOLD;
                end
                default: begin
                    cnt   <= at_end ? '0 : cnt + 1'b1;
                    if (at_end) begin
                        phase   <= PH_IDLE;
                        job_cur <= IDLE_JOB;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/vpc_pin_drive.sv
module vpc_pin_drive
    import vpc_pkg::*;
(
    input  phase_e                phase,
    input  job_t                  job_cur,
    output pins_t [NUM_CHIPS-1:0] pins
);
    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_chip
        logic chosen, strobing;
        assign chosen   = (phase != PH_IDLE) && (job_cur.chip == 1'(c));
        assign strobing = chosen && (phase == PH_STROBE);

        always_comb begin
            pins[c].addr    = chosen ? job_cur.word : '0;
            pins[c].sel_n   = !chosen;
            pins[c].start_n = !(strobing && (job_cur.kind != JOB_LOOP_STOP));
            pins[c].stop_n  = !(strobing && (job_cur.kind == JOB_LOOP_STOP));
            pins[c].rec_n   = 1'b1;
        end
    end
endmodule

// File: rtl/voice_cmd_seq.sv
module voice_cmd_seq
    import vpc_pkg::*;
#(
    parameter int                 SETUP_CYC = 3,
    parameter int                 PULSE_CYC = 4,
    parameter int                 HOLD_CYC  = 2,
    parameter logic [FIELD_W-1:0] ROW_CLIP  = 6'h05,
    parameter logic [FIELD_W-1:0] END_CLIP  = 6'h12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_music_start,
    input  logic       cmd_music_stop,
    input  logic       cmd_clip_play,
    input  logic       clip_sel,
    output logic       busy,
    output logic       music_playing,
    output logic [7:0] bg_addr,
    output logic       bg_cs_n,
    output logic       bg_start_n,
    output logic       bg_stop_n,
    output logic       bg_rec_n,
    output logic [7:0] fx_addr,
    output logic       fx_cs_n,
    output logic       fx_start_n,
    output logic       fx_stop_n,
    output logic       fx_rec_n
);
    logic                  take, seq_busy, seq_done;
    job_t                  req_job, cur_job;
    phase_e                phase;
    pins_t [NUM_CHIPS-1:0] pins;
    logic                  loop_on;

    vpc_cmd_arbiter #(.ROW_CLIP(ROW_CLIP), .END_CLIP(END_CLIP)) u_arb (
        .want_start   (cmd_music_start),
        .want_stop    (cmd_music_stop),
        .want_clip    (cmd_clip_play),
        .clip_choice  (clip_sel),
        .seq_busy     (seq_busy),
        .loop_running (loop_on),
        .take         (take),
        .job          (req_job)
    );

    vpc_strobe_seq #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .job_in   (req_job),
        .phase    (phase),
        .job_cur  (cur_job),
        .seq_busy (seq_busy),
        .seq_done (seq_done)
    );

    vpc_pin_drive u_pins (
        .phase   (phase),
        .job_cur (cur_job),
        .pins    (pins)
    );

    // Playing state follows completed start/stop sequences only.
    always_ff @(posedge clk) begin
        if (rst) begin
            loop_on <= 1'b0;
        end else if (seq_done) begin
            if (cur_job.kind == JOB_LOOP_START) loop_on <= 1'b1;
            else if (cur_job.kind == JOB_LOOP_STOP) loop_on <= 1'b0;
        end
    end

    assign busy          = seq_busy;
    assign music_playing = loop_on;

    assign bg_addr    = pins[CHIP_MUSIC].addr;
    assign bg_cs_n    = pins[CHIP_MUSIC].sel_n;
    assign bg_start_n = pins[CHIP_MUSIC].start_n;
    assign bg_stop_n  = pins[CHIP_MUSIC].stop_n;
    assign bg_rec_n   = pins[CHIP_MUSIC].rec_n;
    assign fx_addr    = pins[CHIP_CLIP].addr;
    assign fx_cs_n    = pins[CHIP_CLIP].sel_n;
    assign fx_start_n = pins[CHIP_CLIP].start_n;
    assign fx_stop_n  = pins[CHIP_CLIP].stop_n;
    assign fx_rec_n   = pins[CHIP_CLIP].rec_n;
endmodule

// File: rtl/vpc_checker.sv
module vpc_checker (
    input logic       clk,
    input logic       rst,
    input logic       cmd_music_start,
    input logic       cmd_music_stop,
    input logic       cmd_clip_play,
    input logic       clip_sel,
    input logic       busy,
    input logic       music_playing,
    input logic [7:0] bg_addr,
    input logic       bg_cs_n,
    input logic       bg_start_n,
    input logic       bg_stop_n,
    input logic       bg_rec_n,
    input logic [7:0] fx_addr,
    input logic       fx_cs_n,
    input logic       fx_start_n,
    input logic       fx_stop_n,
    input logic       fx_rec_n
);
    assert_rec_high_R11: assert property (@(posedge clk) disable iff (rst)
        bg_rec_n && fx_rec_n);

    assert_one_select_R11: assert property (@(posedge clk) disable iff (rst)
        $countones({~bg_cs_n, ~fx_cs_n}) <= 1);

    assert_strobe_under_select_R5: assert property (@(posedge clk) disable iff (rst)
        (!bg_start_n || !bg_stop_n) |-> !bg_cs_n);

    assert_fx_strobe_under_select_R5: assert property (@(posedge clk) disable iff (rst)
        !fx_start_n |-> !fx_cs_n);

    assert_bg_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (!bg_cs_n && $past(!bg_cs_n)) |-> $stable(bg_addr));

    assert_fx_addr_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (!fx_cs_n && $past(!fx_cs_n)) |-> $stable(fx_addr));

    assert_start_word_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(bg_start_n) |-> (bg_addr[7:6] == 2'b11 && bg_addr[3]));

    assert_clip_word_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(fx_start_n) |-> (fx_addr[7:6] == 2'b00));

    assert_fx_no_stop_R4: assert property (@(posedge clk) disable iff (rst)
        fx_stop_n);

    assert_idle_pins_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (bg_cs_n && fx_cs_n && bg_start_n && bg_stop_n && fx_start_n));

    assert_play_rise_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(music_playing) |-> $fell(busy));

    assert_play_fall_at_end_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(music_playing) |-> $fell(busy));
endmodule

bind voice_cmd_seq vpc_checker u_chk (.*);

// File: tb/voice_cmd_seq_tb.sv
module voice_cmd_seq_tb;
    localparam int SETUP = 3;
    localparam int PULSE = 4;
    localparam int HOLD  = 2;
    localparam logic [5:0] ROWC = 6'h05;
    localparam logic [5:0] ENDC = 6'h12;
    localparam logic [7:0] LOOPW = 8'hC8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic c_start = 0, c_stop = 0, c_clip = 0, c_sel = 0;
    logic busy, playing;
    logic [7:0] bg_addr, fx_addr;
    logic bg_cs_n, bg_start_n, bg_stop_n, bg_rec_n;
    logic fx_cs_n, fx_start_n, fx_stop_n, fx_rec_n;

    int total = 0;
    int bad = 0;
    bit model_play = 0;
    bit finished = 0;

    // Event: {chip, is_stop, word}
    logic [9:0] exp_q[$];

    always #4 clk = ~clk;

    voice_cmd_seq #(.SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
                    .ROW_CLIP(ROWC), .END_CLIP(ENDC)) u_dut (
        .clk(clk), .rst(rst),
        .cmd_music_start(c_start), .cmd_music_stop(c_stop),
        .cmd_clip_play(c_clip), .clip_sel(c_sel),
        .busy(busy), .music_playing(playing),
        .bg_addr(bg_addr), .bg_cs_n(bg_cs_n), .bg_start_n(bg_start_n),
        .bg_stop_n(bg_stop_n), .bg_rec_n(bg_rec_n),
        .fx_addr(fx_addr), .fx_cs_n(fx_cs_n), .fx_start_n(fx_start_n),
        .fx_stop_n(fx_stop_n), .fx_rec_n(fx_rec_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compares every strobe against the scoreboard and times it.
    logic [1:0] p_start = 2'b11, p_stop = 2'b11;
    int sel_cnt [2] = '{0, 0};
    int low_cnt [2] = '{0, 0};

    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < 2; c++) begin
                logic s_n, st_n, sp_n;
                logic [7:0] a;
                logic [9:0] got, want;
                s_n  = c ? fx_cs_n    : bg_cs_n;
                st_n = c ? fx_start_n : bg_start_n;
                sp_n = c ? fx_stop_n  : bg_stop_n;
                a    = c ? fx_addr    : bg_addr;
                sel_cnt[c] = s_n ? 0 : sel_cnt[c] + 1;
                if ((p_start[c] && !st_n) || (p_stop[c] && !sp_n)) begin
                    got = {1'(c), !sp_n, a};
                    if (exp_q.size() == 0) begin
                        check(0, "R8 unexpected strobe", got, 0);
                    end else begin
                        want = exp_q.pop_front();
                        check(got == want, "R2/R3/R4/R10 strobe event", got, want);
                    end
                    check(sel_cnt[c] - 1 == SETUP, "R5 setup cycles", sel_cnt[c] - 1, SETUP);
                end
                if (!st_n || !sp_n) begin
                    low_cnt[c]++;
                end else if (low_cnt[c] != 0) begin
                    check(low_cnt[c] == PULSE, "R6 strobe width", low_cnt[c], PULSE);
                    low_cnt[c] = 0;
                end
                p_start[c] = st_n;
                p_stop[c]  = sp_n;
            end
            if (!bg_cs_n && !fx_cs_n) check(0, "R11 both selects low", 0, 1);
            if (!bg_rec_n || !fx_rec_n) check(0, "R11 record strobe low", 0, 1);
        end
    end

    // Driver: predicts acceptance from the requirements, pushes the expectation,
    // pulses the command and checks the busy window and playing flag.
    task automatic issue(input bit s, input bit p, input bit k, input bit sel, input string tag);
        bit take;
        logic [9:0] ev;
        @(negedge clk);
        take = 0;
        if (!busy) begin
            if (p && model_play) begin take = 1; ev = {1'b0, 1'b1, LOOPW}; end
            else if (s && !model_play) begin take = 1; ev = {1'b0, 1'b0, LOOPW}; end
            else if (k) begin take = 1; ev = {1'b1, 1'b0, 2'b00, sel ? ENDC : ROWC}; end
        end
        if (take) exp_q.push_back(ev);
        c_start = s; c_stop = p; c_clip = k; c_sel = sel;
        @(negedge clk);
        c_start = 0; c_stop = 0; c_clip = 0; c_sel = 0;
        if (take) begin
            int n = 0;
            while (busy && n < 100) begin
                n++;
                @(negedge clk);
            end
            check(n == SETUP + PULSE + HOLD, {"R7 busy length ", tag}, n, SETUP + PULSE + HOLD);
            if (ev[9:8] == 2'b00) model_play = 1;
            if (ev[9:8] == 2'b01) model_play = 0;
            check(playing == model_play, {"R9 playing flag ", tag}, playing, model_play);
            check(bg_cs_n && fx_cs_n, {"R7 selects idle ", tag}, {bg_cs_n, fx_cs_n}, 2'b11);
        end else begin
            check(!busy, {"R9 ignored command ", tag}, busy, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(!busy && !playing, "R1 busy/playing", {busy, playing}, 0);
        check(bg_cs_n && fx_cs_n, "R1 selects", {bg_cs_n, fx_cs_n}, 2'b11);
        check(bg_start_n && bg_stop_n && fx_start_n && fx_stop_n && bg_rec_n && fx_rec_n,
              "R1 strobes", {bg_start_n, bg_stop_n, fx_start_n, fx_stop_n}, 4'hF);
        check(bg_addr == 0 && fx_addr == 0, "R1 addresses", {bg_addr, fx_addr}, 0);
        rst = 0;

        issue(0, 0, 1, 0, "R4 row clip");
        issue(0, 0, 1, 1, "R4 end clip");
        issue(1, 0, 0, 0, "R2 start");
        issue(1, 0, 0, 0, "R9 start while playing");
        issue(0, 0, 1, 1, "R4 clip during music");
        issue(0, 1, 1, 0, "R10 stop over clip");
        issue(0, 1, 0, 0, "R9 stop while idle");
        issue(1, 0, 1, 1, "R10 start over clip");
        issue(0, 1, 0, 0, "R3 stop");

        // R8: start offered in the middle of a clip sequence is dropped.
        @(negedge clk);
        exp_q.push_back({1'b1, 1'b0, 2'b00, ROWC});
        c_clip = 1; c_sel = 0;
        @(negedge clk);
        c_clip = 0;
        @(negedge clk);
        check(busy, "R8 busy during clip", busy, 1);
        c_start = 1; c_stop = 1;
        @(negedge clk);
        c_start = 0; c_stop = 0;
        repeat (SETUP + PULSE + HOLD + 4) @(negedge clk);
        check(!busy && !playing, "R8 command during busy ignored", {busy, playing}, 0);

        check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule